// File: doc/BRIEF.md
# Four-Level Priority Transmit Channel Scheduler

This block decides which transmit DMA channel may send its next packet. A channel is pending while its transmit queue holds at least one packet. Queues map onto channels by a fixed offset: a push to queue `QBASE + N` adds one packet to channel N. Every channel carries a 2-bit priority level, set through a small write port. It also has an enable that the downstream streaming side may drop at any moment.

Among channels that are both pending and enabled, the highest level wins. Inside one level a round-robin pointer rotates the choice. A grant is presented as a valid flag plus a channel index and stays fixed for the whole packet, until the end-of-packet acknowledge. Each packet is scheduled on its own, so the descriptor kind behind a packet does not matter here. Descriptor fetch and data movement sit outside this block.

Because higher levels are served strictly first, a busy high-priority channel can starve lower ones. The downstream side can release them by dropping the enable of the busy channel.

Top module: `txch_sched`

## Requirements
- R1: After reset `grant_valid` is 0 and no channel is pending. Every channel's priority level resets to 0, and every round-robin pointer resets to channel 0.
- R2: A cycle with `push_valid` high and `push_qid` equal to `QBASE + N` (0 <= N < NUM_CH) adds one pending packet to channel N. A push with any other queue number changes no channel.
- R3: Level 3 is the highest priority and level 0 the lowest. An eligible channel at a higher level is always granted before any channel at a lower level.
- R4: Within one level the search starts at that level's pointer and goes upward with wrap-around. After a packet of a level completes, that level's pointer becomes the granted channel plus one, modulo NUM_CH.
- R5: While `grant_valid` is high, `grant_ch` stays fixed until `pkt_done` is sampled high. Dropping the granted channel's enable mid-packet does not end the grant.
- R6: A channel whose `ch_enable` bit is 0 is never newly granted. A pending lower-level channel is therefore granted while all higher-level pending channels are disabled.
- R7: When no channel is both pending and enabled, `grant_valid` stays 0.
- R8: Each completed grant removes exactly one pending packet from its channel. The per-channel pending count saturates at 2^CNT_W-1, and pushes beyond that are dropped.
- R9: A cycle with `prio_we` high sets the level of channel `prio_ch` to `prio_val`. The new level is used from the next arbitration.
- R10: `grant_valid` rises one clock edge after the scheduler is idle with an eligible channel. In the cycle after `pkt_done` is accepted, `grant_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | A packet was pushed to queue `push_qid` |
| push_qid | input | QID_W | Queue number of the push |
| prio_we | input | 1 | Priority write strobe |
| prio_ch | input | CH_W | Channel whose level is written |
| prio_val | input | 2 | New priority level (3 highest) |
| ch_enable | input | NUM_CH | Per-channel enable from the downstream streaming side |
| pkt_done | input | 1 | End-of-packet acknowledge for the current grant |
| grant_valid | output | 1 | A channel currently holds a grant |
| grant_ch | output | CH_W | Index of the granted channel |

## Verification
The arbitration is exercised with four kinds of pattern, and each isolates a different fault:
- **All channels at one level with two packets each.** This tells a correct rotating pointer from a fixed-priority or stuck one.
- **A sweep of mixed level assignments, queue fills and single-channel disable masks.** This tells strict level ordering apart from index ordering, and shows that a disabled upper channel lets lower levels through.
- **Pushes just outside the mapped queue range, and an over-full single channel.** These separate correct decoding and saturation from wrap-around or off-by-one.
- **An enable dropped during a granted packet.** This distinguishes holding the grant from re-arbitrating mid-packet.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int PRIO_LEVELS = 4;
  typedef logic [1:0] prio_t;
endpackage

// File: rtl/txs_pend_ctr.sv
module txs_pend_ctr #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (inc && !dec && cnt_q != CMAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/txs_rr_pick.sv
module txs_rr_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = W'(c);
      end
    end
  end
endmodule

// File: rtl/txch_sched.sv
module txch_sched
  import txs_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int QID_W  = 12,
  parameter int QBASE  = 800,
  parameter int CNT_W  = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [QID_W-1:0]  push_qid,
  input  logic              prio_we,
  input  logic [CH_W-1:0]   prio_ch,
  input  logic [1:0]        prio_val,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic              pkt_done,
  output logic              grant_valid,
  output logic [CH_W-1:0]   grant_ch
);
  localparam logic [QID_W-1:0] QLO = QID_W'(QBASE);
  localparam logic [QID_W-1:0] QHI = QID_W'(QBASE + NUM_CH);
  localparam logic [CH_W-1:0]  LAST_CH = CH_W'(NUM_CH - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  // queue-to-channel decode
  logic              push_hit;
  logic [QID_W-1:0]  push_off;
  logic [CH_W-1:0]   push_ch;
  assign push_hit = push_valid && (push_qid >= QLO) && (push_qid < QHI);
  assign push_off = push_qid - QLO;
  assign push_ch  = push_off[CH_W-1:0];

  // grant state
  logic            gv_q, gv_d, g_en;
  logic [CH_W-1:0] gch_q, gch_d;
  prio_t           glvl_q, glvl_d;
  logic            done_fire;
  assign done_fire = gv_q && pkt_done;

  // priority registers
  prio_t prio_q [NUM_CH];
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int c = 0; c < NUM_CH; c++) prio_q[c] <= '0;
    end else if (prio_we) begin
      prio_q[prio_ch] <= prio_val;
    end
  end

  // pending counters and per-level request vectors
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] lvl_req [PRIO_LEVELS];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    txs_pend_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_sn),
      .inc    (push_hit && push_ch == CH_W'(c)),
      .dec    (done_fire && gch_q == CH_W'(c)),
      .nonzero(pend[c])
    );
  end

  always_comb begin
    for (int l = 0; l < PRIO_LEVELS; l++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        lvl_req[l][c] = pend[c] && ch_enable[c] && (prio_q[c] == prio_t'(l));
      end
    end
  end

  // one round-robin picker per level
  logic [CH_W-1:0] rr_ptr_q [PRIO_LEVELS];
  logic [PRIO_LEVELS-1:0] lvl_found;
  logic [CH_W-1:0] lvl_idx [PRIO_LEVELS];

  for (genvar l = 0; l < PRIO_LEVELS; l++) begin : g_lvl
    txs_rr_pick #(.N(NUM_CH), .W(CH_W)) u_pick (
      .req  (lvl_req[l]),
      .ptr  (rr_ptr_q[l]),
      .found(lvl_found[l]),
      .idx  (lvl_idx[l])
    );
  end

  // strict priority across levels: later (higher) levels override
  logic            win_any;
  logic [CH_W-1:0] win_ch;
  prio_t           win_lvl;
  always_comb begin
    win_any = 1'b0;
    win_ch  = '0;
    win_lvl = '0;
    for (int l = 0; l < PRIO_LEVELS; l++) begin
      if (lvl_found[l]) begin
        win_any = 1'b1;
        win_ch  = lvl_idx[l];
        win_lvl = prio_t'(l);
      end
    end
  end

  // grant next state
  always_comb begin
    gv_d   = gv_q;
    gch_d  = gch_q;
    glvl_d = glvl_q;
    g_en   = 1'b0;
    if (gv_q) begin
      if (pkt_done) begin
        gv_d = 1'b0;
        g_en = 1'b1;
      end
    end else if (win_any) begin
      gv_d   = 1'b1;
      gch_d  = win_ch;
      glvl_d = win_lvl;
      g_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gv_q   <= 1'b0;
      gch_q  <= '0;
      glvl_q <= '0;
    end else if (g_en) begin
      gv_q   <= gv_d;
      gch_q  <= gch_d;
      glvl_q <= glvl_d;
    end
  end

  // round-robin pointer update on packet completion
  logic [CH_W-1:0] ptr_next;
  assign ptr_next = (gch_q == LAST_CH) ? '0 : gch_q + 1'b1;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int l = 0; l < PRIO_LEVELS; l++) rr_ptr_q[l] <= '0;
    end else if (done_fire) begin
      rr_ptr_q[glvl_q] <= ptr_next;
    end
  end

  assign grant_valid = gv_q;
  assign grant_ch    = gch_q;
endmodule

// File: rtl/txs_sched_chk.sv
module txs_sched_chk #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_enable,
  input logic              pkt_done,
  input logic              grant_valid,
  input logic [CH_W-1:0]   grant_ch
);
  logic [NUM_CH-1:0] en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= '0;
    else        en_d <= ch_enable;
  end

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !pkt_done |=> grant_valid && $stable(grant_ch));

  // R10
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && pkt_done |=> !grant_valid);

  // R6
  grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> en_d[grant_ch]);

  // R7
  no_enable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable == '0) && !grant_valid |=> !grant_valid);
endmodule

bind txch_sched txs_sched_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_enable  (ch_enable),
  .pkt_done   (pkt_done),
  .grant_valid(grant_valid),
  .grant_ch   (grant_ch)
);

// File: tb/txch_sched_bench.sv
module txch_sched_bench;
  localparam int NCH   = 8;
  localparam int QB    = 800;
  localparam int CMAXV = 15;

  logic       clk, rst_n;
  logic       push_valid;
  logic [11:0] push_qid;
  logic       prio_we;
  logic [2:0] prio_ch;
  logic [1:0] prio_val;
  logic [7:0] ch_enable;
  logic       pkt_done;
  logic       grant_valid;
  logic [2:0] grant_ch;

  txch_sched u_txch_sched (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_qid(push_qid),
    .prio_we(prio_we), .prio_ch(prio_ch), .prio_val(prio_val),
    .ch_enable(ch_enable), .pkt_done(pkt_done),
    .grant_valid(grant_valid), .grant_ch(grant_ch)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int m_cnt [NCH];
  int m_prio [NCH];
  int m_ptr [4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_win();
    for (int l = 3; l >= 0; l--)
      for (int k = 0; k < NCH; k++) begin
        int c;
        c = (m_ptr[l] + k) % NCH;
        if (m_cnt[c] > 0 && ch_enable[c] && m_prio[c] == l) return c;
      end
    return -1;
  endfunction

  task automatic push(input int q, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push_valid = 1'b1;
      push_qid   = 12'(q);
      if (q >= QB && q < QB + NCH && m_cnt[q-QB] < CMAXV) m_cnt[q-QB]++;
    end
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic set_prio(input int c, input int v);
    @(negedge clk);
    prio_we = 1'b1; prio_ch = 3'(c); prio_val = 2'(v);
    m_prio[c] = v;
    @(negedge clk);
    prio_we = 1'b0;
  endtask

  task automatic set_en(input logic [7:0] m);
    @(negedge clk);
    ch_enable = m;
  endtask

  // one arbitration round: check grant, complete packet, check release
  task automatic arb_check(input string req);
    int e;
    @(negedge clk);
    e = exp_win();
    if (e < 0) chk(!grant_valid, req, int'(grant_valid), 0);
    else chk(grant_valid && int'(grant_ch) == e, req,
             grant_valid ? int'(grant_ch) : -1, e);
    if (grant_valid) begin
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
      // R10: low in the cycle after done
      chk(!grant_valid, "R10", int'(grant_valid), 0);
      if (e >= 0) begin
        m_cnt[e]--;
        m_ptr[m_prio[e]] = (e + 1) % NCH;
      end
    end
  endtask

  task automatic drain(input string req, output int n);
    n = 0;
    for (int i = 0; i < 128; i++) begin
      if (exp_win() < 0) break;
      arb_check(req);
      n++;
    end
    arb_check("R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int g;
    rst_n = 1'b0; push_valid = 1'b0; push_qid = '0; prio_we = 1'b0;
    prio_ch = '0; prio_val = '0; ch_enable = '0; pkt_done = 1'b0;
    for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_prio[c] = 0; end
    for (int l = 0; l < 4; l++) m_ptr[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(!grant_valid, "R1", int'(grant_valid), 0);

    // R2: out-of-range pushes are ignored
    push(QB - 1, 1);
    push(QB + NCH, 1);
    set_en(8'hFF);
    repeat (3) arb_check("R2");
    set_en(8'h00);

    // R4 / R8: one level, two packets each, strict rotation
    for (int c = 0; c < NCH; c++) push(QB + c, 2);
    set_en(8'hFF);
    for (int i = 0; i < 2 * NCH; i++) arb_check("R4");
    arb_check("R8");
    set_en(8'h00);

    // R6: high-level channel disabled lets a low level through
    set_prio(1, 3);
    push(QB + 1, 1);
    push(QB + 5, 1);
    set_en(8'b0010_0000);
    arb_check("R6");
    set_en(8'hFF);
    arb_check("R3");
    set_en(8'h00);

    // R5: enable dropped mid-packet keeps the grant
    push(QB + 3, 1);
    set_en(8'b0000_1000);
    @(negedge clk);
    chk(grant_valid && grant_ch == 3'd3, "R5", int'(grant_ch), 3);
    ch_enable = 8'h00;
    repeat (3) begin
      @(negedge clk);
      chk(grant_valid && grant_ch == 3'd3, "R5", int'(grant_ch), 3);
    end
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
    m_cnt[3]--;
    m_ptr[m_prio[3]] = 4;
    chk(!grant_valid, "R10", int'(grant_valid), 0);

    // R3 / R6 / R9 sweep over levels, fills and disable masks
    for (int t = 0; t < 10; t++) begin
      set_en(8'h00);
      for (int c = 0; c < NCH; c++) set_prio(c, (c * 3 + t) % 4);
      for (int c = 0; c < NCH; c++) push(QB + c, (c + t) % 3);
      set_en(8'hFF ^ 8'(1 << (t % NCH)));
      drain("R3", n);
      set_en(8'hFF);
      drain("R9", n);
    end
    set_en(8'h00);

    // R8: saturation of one channel's pending count
    set_prio(2, 1);
    push(QB + 2, CMAXV + 2);
    set_en(8'b0000_0100);
    drain("R8", g);
    chk(g == CMAXV, "R8", g, CMAXV);
    set_en(8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule